// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave with Page Write Buffer

This block is the two-wire bus front end of a small serial EEPROM. It watches the clock and data lines (oversampled by the system clock) and recognises START and STOP conditions. It then decodes a device-select byte and acknowledges only when the byte matches the fixed type code and the address strap inputs. Next it takes a word address and then either accepts write data or streams stored data back to the bus master. The data line is driven open-drain: the only output is a pull-low enable, and the board pull-up provides the high level.

Write data does not go straight into the array. It collects in a 16-byte page buffer, and the low four address bits wrap inside the page. A STOP that follows at least one data byte moves the buffer into the array during a busy period of fixed length. While that period runs, the device refuses its select byte, so a master can poll for the end of the write. Reads auto-increment across the whole array and wrap from the top address to zero. The array size is a parameter. Larger arrays take over strap positions of the select byte as high address bits.

Top module: `i2c_eeprom_top`

## Requirements
- R1: While reset is asserted and after its release with the bus idle, the pull-low output `sda_pull_o` is 0.
- R2: A select byte is recognised when its bits [7:4] are 4'b1010 and every strap-compared position among bits [3:1] equals its strap input. Bit 0 is the direction (0 write, 1 read). A recognised byte is acknowledged by pulling SDA low during the ninth clock.
- R3: With BLK = log2(DENSITY_KBIT) - 1 high address bits (0, 1, 2 or 3 for 2, 4, 8 and 16 Kbit), the top BLK positions of select bits [3:1] carry address bits. Select bit 3 is the most significant address bit. They are never compared with straps, and strap k (compared at select bit k+1) is used only when k < 3 - BLK. In a write select these bits give the upper word-address bits.
- R4: A select byte that does not match is not acknowledged. The block then leaves SDA released for every following clock until the next START.
- R5: In a write, the word-address byte and every data byte are acknowledged. Data byte i lands at the page base plus ((start low nibble + i) mod 16). A later byte overwrites an earlier one that wrapped onto the same location.
- R6: A STOP after at least one data byte moves the page buffer into the array. A START that arrives before that STOP discards the collected bytes, and no write cycle follows.
- R7: For BUSY_CYCLES clocks after a write cycle starts, every select byte is refused. After that the select byte is acknowledged again.
- R8: After a write select, a word address, a repeated START and a read select, bytes are returned MSB first from that address. A master ACK (SDA low on the ninth clock) asks for the next byte. A master NACK releases the bus until the next START.
- R9: Read addresses advance by one over the whole array and wrap from the last address to 0. A read select with no address phase continues from the address after the last byte transferred.
- R10: SDA is sampled at the rising edge of SCL, and `sda_pull_o` changes only while the synchronised SCL is low.
- R11: A START (SDA falling while SCL is high) restarts select-byte reception from any state, including the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strap_i | input | 3 | Device address straps, tied low when unused |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest state to reach from the pins is the acknowledge-polling window: a complete select byte has to arrive while the commit is still running. The bench shortens BUSY_CYCLES so that it is only about twice one byte time. It issues a select byte right after the STOP that ends a page write, then keeps polling. It expects the first poll to be refused and a later poll to be accepted. It also reaches the discard path with a repeated START after a data byte, and the mid-byte restart with a START after three data bits. In both cases it checks the array contents and the busy state afterwards through ordinary reads and polls.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_ACK_DEV,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WDATA,
    ST_ACK_DATA,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } bus_state_e;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_n;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_n;
  logic scl_prev_q, sda_prev_q;

  always_comb begin
    scl_pipe_n = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_n;
      sda_pipe_q <= sda_pipe_n;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s     = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE_BYTES  = 16,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
  input  logic [7:0]                    wr_data,
  input  logic                          discard,
  input  logic                          commit_req,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_base,
  output logic                          busy,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_waddr,
  output logic [7:0]                    mem_wdata
);

  localparam int PIDX_W = $clog2(PAGE_BYTES);
  localparam int CIDX_W = PIDX_W + 1;
  localparam int BASE_W = ADDR_W - PIDX_W;
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

  logic [7:0]            page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic [CIDX_W-1:0]     cidx_q, cidx_n;
  logic [BASE_W-1:0]     base_q, base_n;
  logic [PIDX_W-1:0]     cidx_lo;
  logic                  committing;

  assign busy       = (cnt_q != '0);
  assign cidx_lo    = cidx_q[PIDX_W-1:0];
  assign committing = busy && (cidx_q < CIDX_W'(PAGE_BYTES));

  always_comb begin
    cnt_n  = cnt_q;
    cidx_n = cidx_q;
    mask_n = mask_q;
    base_n = base_q;
    if (busy) begin
      cnt_n = cnt_q - CNT_W'(1);
      if (committing) begin
        cidx_n          = cidx_q + CIDX_W'(1);
        mask_n[cidx_lo] = 1'b0;
      end
    end else begin
      if (commit_req && (mask_q != '0)) begin
        cnt_n  = CNT_W'(BUSY_CYCLES);
        cidx_n = '0;
        base_n = commit_base;
      end else if (discard) begin
        mask_n = '0;
      end
      if (wr_en) mask_n[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cidx_q <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      cnt_q  <= cnt_n;
      cidx_q <= cidx_n;
      mask_q <= mask_n;
      base_q <= base_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !busy) page_q[wr_idx] <= wr_data;
  end

  assign mem_we    = committing && mask_q[cidx_lo];
  assign mem_waddr = {base_q, cidx_lo};
  assign mem_wdata = page_q[cidx_lo];

endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells_q[waddr] <= wdata;
  end

  assign rdata = cells_q[raddr];

endmodule

// File: rtl/i2c_eeprom_top.sv
module i2c_eeprom_top
  import i2c_eeprom_pkg::*;
#(
  parameter int DENSITY_KBIT = 2,
  parameter int PAGE_BYTES   = 16,
  parameter int BUSY_CYCLES  = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);

  localparam int ADDR_W = $clog2(DENSITY_KBIT * 128);
  localparam int NBLK   = ADDR_W - 8;
  localparam int PIDX_W = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  bus_state_e        state_q, state_n;
  logic [2:0]        bitcnt_q, bitcnt_n;
  logic [7:0]        shreg_q, shreg_n;
  logic              full_q, full_n;
  logic              pull_q, pull_n;
  logic              rw_q, rw_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ADDR_W-1:0] addr_load;
  logic              latch_hi, do_load, pb_we;
  logic              busy, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata, rd_data;
  logic [2:0]        strap_ok;
  logic              dev_match;

  // Strap positions in the select byte; the highest ones become address bits.
  for (genvar k = 0; k < 3; k++) begin : g_strap
    if (k < 3 - NBLK) begin : g_cmp
      assign strap_ok[k] = (shreg_q[k+1] == strap_i[k]);
    end else begin : g_blk
      assign strap_ok[k] = 1'b1;
    end
  end

  assign dev_match = (shreg_q[7:4] == DEV_TYPE_CODE) && (&strap_ok);

  if (NBLK > 0) begin : g_hi
    logic [NBLK-1:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_q <= '0;
      else if (latch_hi) hi_q <= shreg_q[3:4-NBLK];
    end
    assign addr_load = {hi_q, shreg_q};
  end else begin : g_nohi
    assign addr_load = shreg_q;
  end

  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    shreg_n  = shreg_q;
    full_n   = full_q;
    pull_n   = pull_q;
    rw_n     = rw_q;
    addr_n   = addr_q;
    latch_hi = 1'b0;
    do_load  = 1'b0;
    pb_we    = 1'b0;
    if (start_evt) begin
      state_n  = ST_DEVSEL;
      bitcnt_n = '0;
      full_n   = 1'b0;
      pull_n   = 1'b0;
    end else if (stop_evt) begin
      state_n = ST_IDLE;
      full_n  = 1'b0;
      pull_n  = 1'b0;
    end else if (scl_rise) begin
      case (state_q)
        ST_DEVSEL, ST_ADDR, ST_WDATA: begin
          if (!full_q) begin
            shreg_n  = {shreg_q[6:0], sda_s};
            bitcnt_n = bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) full_n = 1'b1;
          end
        end
        ST_RACK: if (sda_s) state_n = ST_IGNORE;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_DEVSEL: begin
          if (full_q) begin
            full_n = 1'b0;
            if (dev_match && !busy) begin
              pull_n   = 1'b1;
              state_n  = ST_ACK_DEV;
              rw_n     = shreg_q[0];
              latch_hi = !shreg_q[0];
            end else begin
              state_n = ST_IGNORE;
            end
          end
        end
        ST_ADDR: begin
          if (full_q) begin
            full_n  = 1'b0;
            addr_n  = addr_load;
            pull_n  = 1'b1;
            state_n = ST_ACK_ADDR;
          end
        end
        ST_WDATA: begin
          if (full_q) begin
            full_n  = 1'b0;
            pb_we   = 1'b1;
            addr_n  = {addr_q[ADDR_W-1:PIDX_W], addr_q[PIDX_W-1:0] + PIDX_W'(1)};
            pull_n  = 1'b1;
            state_n = ST_ACK_DATA;
          end
        end
        ST_ACK_DEV: begin
          if (rw_q) begin
            do_load = 1'b1;
          end else begin
            pull_n  = 1'b0;
            state_n = ST_ADDR;
          end
        end
        ST_ACK_ADDR, ST_ACK_DATA: begin
          pull_n  = 1'b0;
          state_n = ST_WDATA;
        end
        ST_RDATA: begin
          if (bitcnt_q == 3'd7) begin
            pull_n  = 1'b0;
            state_n = ST_RACK;
          end else begin
            shreg_n  = {shreg_q[6:0], 1'b0};
            pull_n   = ~shreg_q[6];
            bitcnt_n = bitcnt_q + 3'd1;
          end
        end
        ST_RACK: do_load = 1'b1;
        default: ;
      endcase
      if (do_load) begin
        shreg_n  = rd_data;
        pull_n   = ~rd_data[7];
        bitcnt_n = '0;
        addr_n   = addr_q + ADDR_W'(1);
        state_n  = ST_RDATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      full_q   <= 1'b0;
      pull_q   <= 1'b0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      full_q   <= full_n;
      pull_q   <= pull_n;
      rw_q     <= rw_n;
      addr_q   <= addr_n;
    end
  end

  ee_page_buf #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_page (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pb_we), .wr_idx(addr_q[PIDX_W-1:0]), .wr_data(shreg_q),
    .discard(start_evt), .commit_req(stop_evt),
    .commit_base(addr_q[ADDR_W-1:PIDX_W]),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  ee_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_q), .rdata(rd_data)
  );

  assign sda_pull_o = pull_q;

endmodule

// File: rtl/ee_chk.sv
module ee_chk
  import i2c_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull,
  input logic       scl_s,
  input logic       busy,
  input bus_state_e state,
  input logic       mem_we,
  input logic       start_evt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_QUIET_IN_RESET: assert (!sda_pull); // R1
    end
  end

  AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s); // R10

  AST_BUSY_REFUSES_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state != ST_ACK_DEV); // R7

  AST_IGNORE_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IGNORE |-> !sda_pull); // R4

  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R6

  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEVSEL) && !sda_pull); // R11

endmodule

bind i2c_eeprom_top ee_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .scl_s(scl_s),
  .busy(busy), .state(state_q), .mem_we(mem_we), .start_evt(start_evt)
);

// File: tb/i2c_eeprom_top_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_top_tb;

  localparam int TB_KBIT = 4;
  localparam int SIZE    = TB_KBIT * 128;
  localparam int BUSY    = 600;
  localparam int Q       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic       sda_pull;
  logic       sda_line;

  int total = 0;
  int fails = 0;
  int quiet_viol = 0;
  bit quiet_win = 1'b0;
  int cur_m = 0;
  logic [7:0] mem_m [SIZE];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_eeprom_top #(
    .DENSITY_KBIT(TB_KBIT), .PAGE_BYTES(16), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_pull_o(sda_pull)
  );

  always @(negedge clk) if (quiet_win && sda_pull) quiet_viol++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input int a8, input bit rw);
    return {4'hA, a8[0], 1'b1, 1'b0, rw};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    put_bit(!mack);
  endtask

  task automatic poll(output int polls, output bit first_ack, output bit last_ack);
    bit ack;
    polls = 0;
    first_ack = 1'b0;
    do begin
      bus_start();
      send_byte(sel(0, 1'b0), ack);
      bus_stop();
      if (polls == 0) first_ack = ack;
      polls++;
    end while (!ack && polls < 10);
    last_ack = ack;
  endtask

  task automatic write_page(input int a, input int n, input int seed);
    bit ack;
    int polls;
    bit fa, la;
    logic [7:0] d;
    int base;
    base = a & ~15;
    bus_start();
    send_byte(sel(a >> 8, 1'b0), ack);
    check(ack, "R2 write select ack", ack, 1);
    send_byte(8'(a), ack);
    check(ack, "R5 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      send_byte(d, ack);
      check(ack, "R5 data byte ack", ack, 1);
      mem_m[base | ((a + i) & 15)] = d;
    end
    bus_stop();
    cur_m = base | ((a + n) & 15);
    poll(polls, fa, la);
    check(!fa, "R7 first poll refused while busy", fa, 0);
    check(la, "R7 poll accepted after busy period", la, 1);
    check(polls >= 2, "R6 write cycle started by STOP", polls, 2);
  endtask

  task automatic read_data(input int a, input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      check(d == mem_m[(a + i) % SIZE], req, d, mem_m[(a + i) % SIZE]);
    end
    bus_stop();
    cur_m = (a + n) % SIZE;
  endtask

  task automatic read_seq(input int a, input int n, input string req);
    bit ack;
    bus_start();
    send_byte(sel(a >> 8, 1'b0), ack);
    check(ack, "R8 dummy write select ack", ack, 1);
    send_byte(8'(a), ack);
    check(ack, "R8 read address ack", ack, 1);
    bus_start();
    send_byte(sel(0, 1'b1), ack);
    check(ack, "R8 read select ack", ack, 1);
    read_data(a, n, req);
  endtask

  task automatic read_cur(input int n, input string req);
    bit ack;
    bus_start();
    send_byte(sel(0, 1'b1), ack);
    check(ack, "R9 current read select ack", ack, 1);
    read_data(cur_m, n, req);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ack;
    int polls;
    bit fa, la;
    logic [7:0] old5;

    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R1 released during reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);

    // R4: wrong strap value, then further bytes must see a silent slave
    bus_start();
    send_byte({4'hA, 1'b0, 2'b00, 1'b0}, ack);
    check(!ack, "R4 strap mismatch refused", ack, 0);
    quiet_win = 1'b1;
    send_byte(8'h00, ack);
    check(!ack, "R4 ignored byte after mismatch", ack, 0);
    send_byte(sel(0, 1'b0), ack);
    check(!ack, "R4 matching byte still ignored before START", ack, 0);
    quiet_win = 1'b0;
    check(quiet_viol == 0, "R4 no pull while ignoring", quiet_viol, 0);
    bus_stop();

    // R2: wrong type code
    bus_start();
    send_byte(8'hB4, ack);
    check(!ack, "R2 wrong type code refused", ack, 0);
    bus_stop();

    // R5 R6 R7 R3: page write in upper block, then read back
    write_page(12'h123, 4, 8'h11);
    read_seq(12'h123, 4, "R3 R8 read back upper block");

    // R5: 18 bytes wrap inside page 0
    write_page(12'h00E, 18, 8'h40);
    read_seq(12'h000, 16, "R5 page wrap contents");

    // R9: rollover from top address, then current address read
    write_page(12'h1FF, 1, 8'h5A);
    read_seq(12'h1FF, 2, "R9 rollover to address 0");
    read_cur(1, "R9 current address read");

    // R6: repeated START discards collected data
    old5 = mem_m[5];
    bus_start();
    send_byte(sel(0, 1'b0), ack);
    send_byte(8'h05, ack);
    send_byte(8'hEE, ack);
    check(ack, "R6 data byte before discard ack", ack, 1);
    bus_start();
    bus_stop();
    poll(polls, fa, la);
    check(fa, "R6 no write cycle after discard", fa, 1);
    read_seq(5, 1, "R6 discarded byte not stored");
    check(mem_m[5] == old5, "R6 model unchanged", mem_m[5], old5);

    // R3: strap 2 is an address position at 4 Kbit and is not compared
    strap = 3'b110;
    repeat (4) @(negedge clk);
    bus_start();
    send_byte(sel(0, 1'b0), ack);
    check(ack, "R3 unused strap ignored", ack, 1);
    bus_stop();

    // R11: START in the middle of a byte restarts reception
    bus_start();
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    read_seq(12'h123, 2, "R11 restart mid byte then read");

    // R10: timing of output changes is covered by reads above; final idle
    repeat (20) @(negedge clk);
    check(sda_pull == 1'b0, "R10 bus released at end", sda_pull, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule